// File: doc/BRIEF.md
# Capture Ring Writer for Audio Samples

This block moves received audio words into a circular buffer in memory. A serial audio receiver hands it 32-bit little-endian samples over a valid/ready stream. Each sample becomes a single word write at the ring base plus the current fill offset. Software places the ring by giving a base address and a power-of-two byte size (at most 2 MiB). It frees space by advancing a consumer offset. The hardware owns the fill offset and moves it forward in bytes, wrapping at the ring size.

The writer always leaves one word slot empty. An empty ring and a full ring therefore never look alike. When the next slot would land on the consumer offset, the writer stops taking samples until software moves that offset. The frame width in bytes is a configuration input (channel count times four). The block counts completed frames and, after a programmed number of frames, latches a receive status bit. A mask bit and a configuration enable bit gate that status onto the interrupt line.

Software sees two register regions on one bus, chosen by a region-select input. Reads return data one cycle after the read strobe.

Top module: `capdma_ring_writer`

## Requirements
- R1: The main region maps run enable (bit 0) at 0x14, ring base at 0x18, ring size in bytes at 0x1c, fill offset at 0x20, consumer offset at 0x24, and period setup at 0x4c (frame count in bits [31:8], interrupt enable in bit 0). The interrupt region maps the mask at 0x08 and the status at 0x0c. Written values read back, and a write to the fill offset at 0x20 has no effect.
- R2: Every accepted sample produces exactly one memory request, with address = base + fill offset and data = the sample. The request, address and data hold steady until the acknowledge arrives.
- R3: On each acknowledged write the fill offset grows by 4 modulo the ring size, and it changes at no other time except when it is cleared.
- R4: No sample is accepted while (fill offset + 4) mod size equals the consumer offset. Acceptance resumes once software moves the consumer offset.
- R5: While run enable is 0, the block makes no memory request and accepts no sample, the fill offset reads 0 and the frame and period counts are cleared.
- R6: Writing 1 to bit 0 of 0x2c clears the fill offset, the frame count and the period count, and drops any pending word. Writing only bit 1 of 0x2c leaves the capture path untouched.
- R7: A frame completes when its acknowledged bytes reach the frame-size input. When the completed frame count reaches the period field, status bit 0 is set and the count restarts. A period field of 0 never sets status.
- R8: Writing 1 to bit 0 of the status register at 0x0c clears it. A new period event in the same cycle wins over the clear.
- R9: The interrupt output is registered and equals status AND mask bit 0 AND the period-setup interrupt enable, one cycle later.
- R10: After reset every register reads 0, and the interrupt, request and ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_isel | input | 1 | 1 selects the interrupt region, 0 the main region |
| bus_addr | input | 8 | Byte offset within the selected region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| frame_bytes | input | 10 | Bytes per frame (channels times 4) |
| smp_valid | input | 1 | Sample available |
| smp_data | input | 32 | Sample word |
| smp_ready | output | 1 | Sample taken when high with smp_valid |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the word |
| mem_data | output | 32 | Word to write |
| mem_ack | input | 1 | Write accepted |
| irq | output | 1 | Receive interrupt |

## Verification
The embedded properties check every cycle that a waiting request keeps its address and data, that the fill offset moves by exactly one word per acknowledge, that it is zero after a disable or soft clear, that a blocked slot keeps the writer idle, and how status responds to period events and clears. Only the bench scenarios can show the end-to-end results. These include the exact stall point with the consumer at 0 and after it moves, wrap-around addresses, period timing with random acknowledge delays, and the interrupt with its mask or enable off. They also cover the no-effect writes and the register readback.

// File: rtl/capdma_pkg.sv
package capdma_pkg;
  // main region offsets
  localparam logic [7:0] OFS_RUN   = 8'h14;
  localparam logic [7:0] OFS_BASE  = 8'h18;
  localparam logic [7:0] OFS_SIZE  = 8'h1c;
  localparam logic [7:0] OFS_FILL  = 8'h20;
  localparam logic [7:0] OFS_CONS  = 8'h24;
  localparam logic [7:0] OFS_SCLR  = 8'h2c;
  localparam logic [7:0] OFS_PSET  = 8'h4c;
  // interrupt region offsets
  localparam logic [7:0] OFS_IMASK = 8'h08;
  localparam logic [7:0] OFS_ISTAT = 8'h0c;

  localparam int WORD_BYTES = 4;

  typedef enum logic {WS_IDLE, WS_WAIT} wr_state_e;
endpackage

// File: rtl/capdma_regs.sv
module capdma_regs
  import capdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 22,
  parameter int PER_W  = 24,
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_isel,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [IDX_W-1:0]  fill_i,
  input  logic              imask_i,
  input  logic              istat_i,
  output logic              run_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [IDX_W-1:0]  size_o,
  output logic [IDX_W-1:0]  cons_o,
  output logic [PER_W-1:0]  per_o,
  output logic              pirq_en_o,
  output logic              sclr_o
);
  localparam int PER_LSB = 8;

  logic        wr_main;
  logic [31:0] rd_mux;

  assign wr_main = bus_wr && !bus_isel;
  // soft clear acts on the same edge as the write
  assign sclr_o  = wr_main && (bus_addr == BUS_AW'(OFS_SCLR)) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o     <= 1'b0;
      base_o    <= '0;
      size_o    <= '0;
      cons_o    <= '0;
      per_o     <= '0;
      pirq_en_o <= 1'b0;
    end else if (wr_main) begin
      case (bus_addr)
        BUS_AW'(OFS_RUN):  run_o  <= bus_wdata[0];
        BUS_AW'(OFS_BASE): base_o <= bus_wdata[ADDR_W-1:0];
        BUS_AW'(OFS_SIZE): size_o <= bus_wdata[IDX_W-1:0];
        BUS_AW'(OFS_CONS): cons_o <= bus_wdata[IDX_W-1:0];
        BUS_AW'(OFS_PSET): begin
          per_o     <= bus_wdata[PER_LSB +: PER_W];
          pirq_en_o <= bus_wdata[0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_isel) begin
      if (bus_addr == BUS_AW'(OFS_IMASK))      rd_mux[0] = imask_i;
      else if (bus_addr == BUS_AW'(OFS_ISTAT)) rd_mux[0] = istat_i;
    end else begin
      case (bus_addr)
        BUS_AW'(OFS_RUN):  rd_mux[0]          = run_o;
        BUS_AW'(OFS_BASE): rd_mux[ADDR_W-1:0] = base_o;
        BUS_AW'(OFS_SIZE): rd_mux[IDX_W-1:0]  = size_o;
        BUS_AW'(OFS_FILL): rd_mux[IDX_W-1:0]  = fill_i;
        BUS_AW'(OFS_CONS): rd_mux[IDX_W-1:0]  = cons_o;
        BUS_AW'(OFS_PSET): begin
          rd_mux[PER_LSB +: PER_W] = per_o;
          rd_mux[0]                = pirq_en_o;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/capdma_writer.sv
module capdma_writer
  import capdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 22,
  parameter int PER_W  = 24,
  parameter int FRM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              sclr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  size_i,
  input  logic [IDX_W-1:0]  cons_i,
  input  logic [PER_W-1:0]  per_i,
  input  logic [FRM_W-1:0]  frame_bytes_i,
  input  logic              smp_valid_i,
  input  logic [31:0]       smp_data_i,
  output logic              smp_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_data_o,
  input  logic              mem_ack_i,
  output logic [IDX_W-1:0]  fill_o,
  output logic              evt_o
);
  wr_state_e        st_q;
  logic [IDX_W-1:0] ring_mask, nxt_idx;
  logic [FRM_W-1:0] fb_q;
  logic [PER_W-1:0] pc_q;
  logic             clr, take, done, frame_end, per_hit;

  assign ring_mask   = size_i - 1'b1;
  assign nxt_idx     = (fill_o + IDX_W'(WORD_BYTES)) & ring_mask;
  assign clr         = !run_i || sclr_i;
  assign smp_ready_o = run_i && !sclr_i && (st_q == WS_IDLE) && (nxt_idx != cons_i);
  assign take        = smp_valid_i && smp_ready_o;
  assign done        = (st_q == WS_WAIT) && mem_ack_i;
  assign mem_req_o   = (st_q == WS_WAIT) && run_i;
  assign frame_end   = ({1'b0, fb_q} + (FRM_W+1)'(WORD_BYTES)) >= {1'b0, frame_bytes_i};
  assign per_hit     = (per_i != '0) && (({1'b0, pc_q} + (PER_W+1)'(1)) >= {1'b0, per_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= WS_IDLE;
      fill_o     <= '0;
      fb_q       <= '0;
      pc_q       <= '0;
      evt_o      <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else if (clr) begin
      st_q   <= WS_IDLE;
      fill_o <= '0;
      fb_q   <= '0;
      pc_q   <= '0;
      evt_o  <= 1'b0;
    end else begin
      evt_o <= 1'b0;
      if (done) begin
        st_q   <= WS_IDLE;
        fill_o <= nxt_idx;
        if (frame_end) begin
          fb_q <= '0;
          if (per_hit) begin
            pc_q  <= '0;
            evt_o <= 1'b1;
          end else begin
            pc_q <= pc_q + 1'b1;
          end
        end else begin
          fb_q <= fb_q + FRM_W'(WORD_BYTES);
        end
      end else if (take) begin
        st_q       <= WS_WAIT;
        mem_addr_o <= base_i + ADDR_W'(fill_o);
        mem_data_o <= smp_data_i;
      end
    end
  end

  // R2: a waiting word keeps its request, address and data
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i && !sclr_i) |=>
      (!run_i || (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o))));

  // R3: one word of progress per acknowledge, wrapped to the ring
  p_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> (fill_o == (($past(fill_o) + IDX_W'(WORD_BYTES)) & $past(ring_mask))));

  p_align_r3: assert property (@(posedge clk) disable iff (rst)
    fill_o[1:0] == 2'b00);

  // R4: a blocked slot keeps the writer idle
  p_no_full_r4: assert property (@(posedge clk) disable iff (rst)
    ((st_q == WS_IDLE) && smp_valid_i && (nxt_idx == cons_i)) |=> (st_q == WS_IDLE));

  // R5: disabled means cleared and silent
  p_off_r5: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (fill_o == '0 && !mem_req_o));

  // R6: soft clear zeroes the fill offset
  p_sclr_r6: assert property (@(posedge clk) disable iff (rst)
    sclr_i |=> (fill_o == '0));
endmodule

// File: rtl/capdma_irq.sv
module capdma_irq
  import capdma_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              bus_wr,
  input  logic              bus_isel,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wbit0,
  input  logic              pirq_en_i,
  output logic              mask_o,
  output logic              stat_o,
  output logic              irq_o
);
  logic wr_irq, stat_clr;

  assign wr_irq   = bus_wr && bus_isel;
  assign stat_clr = wr_irq && (bus_addr == BUS_AW'(OFS_ISTAT)) && bus_wbit0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= 1'b0;
      stat_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_irq && (bus_addr == BUS_AW'(OFS_IMASK))) mask_o <= bus_wbit0;
      if (evt_i)         stat_o <= 1'b1;
      else if (stat_clr) stat_o <= 1'b0;
      irq_o <= stat_o && mask_o && pirq_en_i;
    end
  end

  // R7: a period event always lands in status
  p_set_r7: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> stat_o);

  // R8: write-one clears unless an event collides
  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !evt_i) |=> !stat_o);
endmodule

// File: rtl/capdma_ring_writer.sv
module capdma_ring_writer
  import capdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 22,
  parameter int PER_W  = 24,
  parameter int FRM_W  = 10,
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_isel,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [FRM_W-1:0]  frame_bytes,
  input  logic              smp_valid,
  input  logic [31:0]       smp_data,
  output logic              smp_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  input  logic              mem_ack,
  output logic              irq
);
  logic              run, sclr, pirq_en, imask, istat, evt;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  size, cons, fill;
  logic [PER_W-1:0]  per;

  capdma_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PER_W(PER_W), .BUS_AW(BUS_AW)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_isel(bus_isel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fill_i(fill), .imask_i(imask), .istat_i(istat),
    .run_o(run), .base_o(base), .size_o(size), .cons_o(cons), .per_o(per),
    .pirq_en_o(pirq_en), .sclr_o(sclr)
  );

  capdma_writer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PER_W(PER_W), .FRM_W(FRM_W)) u_writer (
    .clk(clk), .rst(rst), .run_i(run), .sclr_i(sclr), .base_i(base), .size_i(size),
    .cons_i(cons), .per_i(per), .frame_bytes_i(frame_bytes),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .smp_ready_o(smp_ready),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_ack_i(mem_ack), .fill_o(fill), .evt_o(evt)
  );

  capdma_irq #(.BUS_AW(BUS_AW)) u_irq (
    .clk(clk), .rst(rst), .evt_i(evt), .bus_wr(bus_wr), .bus_isel(bus_isel),
    .bus_addr(bus_addr), .bus_wbit0(bus_wdata[0]), .pirq_en_i(pirq_en),
    .mask_o(imask), .stat_o(istat), .irq_o(irq)
  );
endmodule

// File: tb/capdma_ring_writer_tb.sv
`timescale 1ns/1ps
module capdma_ring_writer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_isel = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  frame_bytes = 10'd8;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        smp_ready, mem_req, mem_ack = 1'b0, irq;
  logic [31:0] mem_addr, mem_data;

  always #2 clk = ~clk;

  capdma_ring_writer u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_isel(bus_isel),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_bytes(frame_bytes), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ack(mem_ack), .irq(irq)
  );

  int checks = 0, errors = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  bit          m_run, m_pirq, m_mask, m_stat, m_irq, m_pend, m_evt, m_acc;
  logic [31:0] m_base, m_addr, m_data;
  int          m_size, m_cons, m_per, m_fill, m_fb, m_pc;

  function automatic int ring_and();
    return (m_size - 1) & 32'h3FFFFF;
  endfunction

  function automatic bit sclr_now();
    return bus_wr && !bus_isel && bus_addr == 8'h2c && bus_wdata[0];
  endfunction

  function automatic bit ready_now();
    return m_run && !m_pend && !sclr_now() && (((m_fill + 4) & ring_and()) != m_cons);
  endfunction

  always @(posedge clk) begin
    bit take, ack;
    if (rst) begin
      m_run = 0; m_pirq = 0; m_mask = 0; m_stat = 0; m_irq = 0; m_pend = 0;
      m_evt = 0; m_acc = 0; m_base = '0; m_addr = '0; m_data = '0;
      m_size = 0; m_cons = 0; m_per = 0; m_fill = 0; m_fb = 0; m_pc = 0;
    end else begin
      take = smp_valid && ready_now();
      ack  = m_pend && mem_ack;
      m_irq = m_stat && m_mask && m_pirq;
      if (m_evt) m_stat = 1;
      else if (bus_wr && bus_isel && bus_addr == 8'h0c && bus_wdata[0]) m_stat = 0;
      m_acc = 0;
      if (!m_run || sclr_now()) begin
        m_pend = 0; m_fill = 0; m_fb = 0; m_pc = 0; m_evt = 0;
      end else begin
        m_evt = 0;
        if (ack) begin
          m_pend = 0;
          m_fill = (m_fill + 4) & ring_and();
          if (m_fb + 4 >= int'(frame_bytes)) begin
            m_fb = 0;
            if (m_per != 0 && m_pc + 1 >= m_per) begin m_pc = 0; m_evt = 1; end
            else m_pc++;
          end else m_fb += 4;
        end else if (take) begin
          m_pend = 1; m_addr = m_base + 32'(m_fill); m_data = smp_data; m_acc = 1;
        end
      end
      if (bus_wr && bus_isel && bus_addr == 8'h08) m_mask = bus_wdata[0];
      if (bus_wr && !bus_isel) begin
        case (bus_addr)
          8'h14: m_run = bus_wdata[0];
          8'h18: m_base = bus_wdata;
          8'h1c: m_size = int'(bus_wdata & 32'h3FFFFF);
          8'h24: m_cons = int'(bus_wdata & 32'h3FFFFF);
          8'h4c: begin m_per = int'(bus_wdata[31:8]); m_pirq = bus_wdata[0]; end
          default: ;
        endcase
      end
    end
    #1;
    if (!rst) begin
      chk("R2", "mem_req", mem_req, m_pend && m_run);
      if (m_pend && m_run) begin
        chk("R3", "mem_addr", mem_addr, m_addr);
        chk("R2", "mem_data", mem_data, m_data);
      end
      chk("R4", "smp_ready", smp_ready, ready_now());
      chk("R9", "irq", irq, m_irq);
    end
  end

  // sample source
  bit src_on = 0;
  int src_cnt = 0;
  always @(negedge clk) begin
    if (m_acc) src_cnt++;
    smp_valid = src_on;
    smp_data  = 32'hA500_0000 + src_cnt;
  end

  // memory responder with random delay
  int ack_wait = 0;
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (ack_wait == 0) begin
        mem_ack = 1'b1;
        ack_wait = $urandom_range(0, 3);
      end else ack_wait--;
    end else mem_ack = 1'b0;
  end

  task automatic wr(bit isel, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_isel = isel; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(bit isel, logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_isel = isel; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    // R10: reset state
    rd(0, 8'h14, v); chk("R10", "run after reset", v, 0);
    rd(0, 8'h20, v); chk("R10", "fill after reset", v, 0);
    rd(1, 8'h0c, v); chk("R10", "status after reset", v, 0);
    chk("R10", "irq after reset", irq, 0);
    chk("R10", "ready after reset", smp_ready, 0);

    // configure: 32-byte ring, consumer 0, 2 frames of 8 bytes per period
    wr(0, 8'h18, 32'h8000_1000);
    wr(0, 8'h1c, 32'd32);
    wr(0, 8'h24, 32'd0);
    wr(0, 8'h4c, (32'd2 << 8) | 32'd1);
    wr(1, 8'h08, 32'd1);
    wr(0, 8'h14, 32'd1);
    rd(0, 8'h18, v); chk("R1", "base readback", v, 32'h8000_1000);
    rd(0, 8'h1c, v); chk("R1", "size readback", v, 32'd32);
    rd(0, 8'h4c, v); chk("R1", "period setup readback", v, (32'd2 << 8) | 32'd1);

    // R4: fill until the slot before the consumer
    src_on = 1;
    idle(80);
    chk("R4", "ready at full point", smp_ready, 0);
    rd(0, 8'h20, v); chk("R4", "fill stalls at 28", v, 28);
    rd(1, 8'h0c, v); chk("R7", "status after period", v, 1);
    chk("R9", "irq with mask and enable", irq, 1);

    // R8: write-one clear
    wr(1, 8'h0c, 32'd1);
    idle(2);
    rd(1, 8'h0c, v); chk("R8", "status cleared", v, 0);
    chk("R9", "irq follows clear", irq, 0);

    // R1: fill offset not writable
    wr(0, 8'h20, 32'h10);
    rd(0, 8'h20, v); chk("R1", "fill ignores write", v, 28);

    // R4: consumer moves, wrap continues to 12
    wr(0, 8'h24, 32'd16);
    idle(60);
    rd(0, 8'h20, v); chk("R4", "fill resumes and wraps", v, 12);
    rd(1, 8'h0c, v); chk("R7", "status after wrapped period", v, 1);

    // R6: bit 1 has no effect, bit 0 clears
    wr(0, 8'h2c, 32'd2);
    rd(0, 8'h20, v); chk("R6", "transmit bit leaves fill", v, 12);
    src_on = 0;
    idle(10);
    wr(0, 8'h2c, 32'd1);
    rd(0, 8'h20, v); chk("R6", "soft clear zeroes fill", v, 0);

    // R9: masked interrupt; period restarts from zero
    wr(1, 8'h0c, 32'd1);
    wr(1, 8'h08, 32'd0);
    frame_bytes = 10'd4;
    src_on = 1;
    idle(60);
    rd(0, 8'h20, v); chk("R6", "refill after clear", v, 12);
    rd(1, 8'h0c, v); chk("R7", "status after single-word frames", v, 1);
    chk("R9", "irq masked", irq, 0);

    // R9: interrupt enable off, mask on
    wr(1, 8'h08, 32'd1);
    wr(0, 8'h4c, (32'd2 << 8));
    idle(3);
    chk("R9", "irq with period enable off", irq, 0);

    // R7: period 0 never sets status
    wr(0, 8'h4c, 32'd1);
    wr(1, 8'h0c, 32'd1);
    wr(0, 8'h24, 32'd0);
    idle(60);
    rd(0, 8'h20, v); chk("R4", "fill stalls at 28 again", v, 28);
    rd(1, 8'h0c, v); chk("R7", "period 0 gives no status", v, 0);

    // R5: disable with samples still offered
    wr(0, 8'h24, 32'd16);
    wr(0, 8'h14, 32'd0);
    idle(5);
    chk("R5", "no request when disabled", mem_req, 0);
    chk("R5", "no ready when disabled", smp_ready, 0);
    rd(0, 8'h20, v); chk("R5", "fill zero when disabled", v, 0);

    src_on = 0;
    idle(2);
    finish_run();
  end
endmodule